// File: doc/BRIEF.md
# Stride-Freeze Address Bus Codec

This block lowers switching on an address bus whose addresses usually advance by a fixed step. The transmit side compares each new source address with the one before it. If the new address is exactly one stride further on, the transmit side leaves the bus lines untouched and raises a single increment flag. If not, it drives the new address onto the bus and clears the flag. The receive side rebuilds each address. It adds the stride to its own last output when the flag is high, and takes the bus value when the flag is low. The stride is a design parameter that both sides share.

The transmit side is a two-state machine. `LINK_LIVE` means the bus carries the last address that was not in sequence and the flag is low. `LINK_FROZEN` means the bus is held and the flag is high. A valid address that is in sequence moves the machine to `LINK_FROZEN`, which is the *hit* transition. A valid address that is out of sequence moves it to `LINK_LIVE`, which is the *miss* transition. A cycle with no valid input keeps the current state, which is the *idle* transition. The bus register and the flag change one cycle after a valid input. The receive side registers its result from the link one cycle later, so the decoded address appears two cycles after the input. All address arithmetic wraps modulo 2^ADDR_W.

Top module: `stride_bus_codec`

## Requirements
- R1: When `in_valid` is high and `in_addr` equals the previous valid source address plus STRIDE, then on the next cycle `inc_out` is 1 and `bus_out` keeps its value.
- R2: When `in_valid` is high and `in_addr` is not the previous valid source address plus STRIDE, then on the next cycle `bus_out` equals that `in_addr` and `inc_out` is 0.
- R3: The sequence test uses the last valid source address, not the value held on the bus. A run of consecutive stride steps therefore keeps `inc_out` at 1 for every step.
- R4: The stride addition wraps modulo 2^ADDR_W. With STRIDE=1 and ADDR_W=8, address 0x00 that follows 0xFF is a hit.
- R5: While `rst_n` is low, `bus_out`, `inc_out`, `dec_addr` and the stored previous source address are all 0. The first valid address after reset is therefore a hit only if it equals STRIDE.
- R6: A cycle with `in_valid` low leaves `bus_out`, `inc_out` and `dec_addr` unchanged, and it does not alter the previous address used by R1.
- R7: Two cycles after a valid input, `dec_addr` equals that input address. It is the last decoded address plus STRIDE when the flag was 1, and the bus value otherwise.
- R8: With STRIDE=1 and ADDR_W=8, the address stream 4,5,6,7,8,6,7,8 following a non-adjacent address gives bus values 4,4,4,4,4,6,6,6 with flag values 0,1,1,1,1,0,1,1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A source address is present this cycle |
| in_addr | input | ADDR_W | Source address |
| bus_out | output | ADDR_W | Coded bus lines |
| inc_out | output | 1 | Increment flag: 1 means the bus is frozen and the address stepped by STRIDE |
| dec_addr | output | ADDR_W | Address rebuilt by the receive side |

## Verification
The hardest case to reach from the ports is a long frozen run. During that run the bus no longer shows the source address, so a design that compares with the bus instead of the stored source goes wrong only on the second or later step. Idle gaps inside such a run, and the step across the top of the address range, are also hard to reach. The bench sweeps every 8-bit starting address. From each one it plays a run of stride steps, an idle cycle, a further step, a backward jump and a scrambled address. It also checks the wrap step and the resets with first addresses equal to and different from the stride.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    // Transmit-side link state: bus carrying a fresh address, or held with flag up
    typedef enum logic {
        LINK_LIVE   = 1'b0,
        LINK_FROZEN = 1'b1
    } link_state_e;
endpackage

// File: rtl/sbc_encoder.sv
module sbc_encoder
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STRIDE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] bus_q,
    output logic              inc_q,
    output logic              strobe_q
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    link_state_e       state, state_nx;
    logic [ADDR_W-1:0] last_src;
    logic [ADDR_W-1:0] expect_addr;
    logic              hit;

    assign expect_addr = last_src + STEP;
    assign hit         = src_valid && (src_addr == expect_addr);

    // next-state decision: hit -> frozen, miss -> live, idle -> stay
    always_comb begin
        state_nx = state;
        unique case (state)
            LINK_LIVE:   if (hit) state_nx = LINK_FROZEN;
            LINK_FROZEN: if (src_valid && !hit) state_nx = LINK_LIVE;
            default:     state_nx = LINK_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LINK_LIVE;
        else        state <= state_nx;
    end

    // registered outputs and source history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q    <= '0;
            last_src <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= src_valid;
            if (src_valid) begin
                last_src <= src_addr;
                if (!hit) bus_q <= src_addr;
            end
        end
    end

    assign inc_q = (state == LINK_FROZEN);
endmodule

// File: rtl/sbc_decoder.sv
module sbc_decoder #(
    parameter int ADDR_W = 8,
    parameter int STRIDE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_strobe,
    input  logic [ADDR_W-1:0] link_bus,
    input  logic              link_inc,
    output logic [ADDR_W-1:0] addr_q
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] rebuilt;

    always_comb begin
        rebuilt = link_inc ? (addr_q + STEP) : link_bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           addr_q <= '0;
        else if (link_strobe) addr_q <= rebuilt;
    end
endmodule

// File: rtl/stride_bus_codec.sv
module stride_bus_codec #(
    parameter int ADDR_W = 8,
    parameter int STRIDE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic [ADDR_W-1:0] bus_out,
    output logic              inc_out,
    output logic [ADDR_W-1:0] dec_addr
);
    logic link_strobe;

    sbc_encoder #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (in_valid),
        .src_addr  (in_addr),
        .bus_q     (bus_out),
        .inc_q     (inc_out),
        .strobe_q  (link_strobe)
    );

    sbc_decoder #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_strobe (link_strobe),
        .link_bus    (bus_out),
        .link_inc    (inc_out),
        .addr_q      (dec_addr)
    );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int ADDR_W = 8,
    parameter int STRIDE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic [ADDR_W-1:0] bus_out,
    input logic              inc_out,
    input logic [ADDR_W-1:0] dec_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] ck_last;
    logic [ADDR_W-1:0] ck_a1;
    logic              ck_v1;
    logic [ADDR_W-1:0] ck_next;

    assign ck_next = ck_last + STEP;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_last <= '0;
            ck_a1   <= '0;
            ck_v1   <= 1'b0;
        end else begin
            ck_v1 <= in_valid;
            if (in_valid) begin
                ck_last <= in_addr;
                ck_a1   <= in_addr;
            end
        end
    end

    a_r1_hit_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr == ck_next) |=> (inc_out && $stable(bus_out)));

    a_r2_miss_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr != ck_next) |=> (!inc_out && bus_out == $past(in_addr)));

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(bus_out) && $stable(inc_out)));

    a_r7_dec_match: assert property (@(posedge clk) disable iff (!rst_n)
        ck_v1 |=> (dec_addr == $past(ck_a1)));

    a_r6_dec_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_v1 |=> $stable(dec_addr));
endmodule

bind stride_bus_codec sbc_checker #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_addr  (in_addr),
    .bus_out  (bus_out),
    .inc_out  (inc_out),
    .dec_addr (dec_addr)
);

// File: tb/tb_stride_bus_codec.sv
module tb_stride_bus_codec;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_addr = '0;
    logic [W-1:0] bus_out;
    logic         inc_out;
    logic [W-1:0] dec_addr;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench model, arithmetic only
    logic [W-1:0] m_last, m_bus;
    logic         m_inc;

    stride_bus_codec #(.ADDR_W(W), .STRIDE(1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .bus_out(bus_out), .inc_out(inc_out), .dec_addr(dec_addr)
    );

    always #5 clk = ~clk;

    task automatic report(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        m_last = '0; m_bus = '0; m_inc = 1'b0;
        vectors++;
        report("R5", "bus_out", int'(bus_out), 0);
        report("R5", "inc_out", int'(inc_out), 0);
        report("R5", "dec_addr", int'(dec_addr), 0);
        rst_n = 1'b1;
    endtask

    // drive at a falling edge, check one cycle later at the next falling edge
    task automatic apply(input logic v, input logic [W-1:0] a, input string force_tag);
        logic [W-1:0] exp_dec;
        logic         hit;
        string        tag;
        in_valid = v; in_addr = a;
        @(posedge clk);
        @(negedge clk);
        exp_dec = m_last;
        hit = v && (a == W'(m_last + 8'd1));
        if (!v) tag = "R6";
        else if (hit) tag = "R1";
        else tag = "R2";
        if (force_tag != "") tag = force_tag;
        if (v) begin
            if (hit) m_inc = 1'b1;
            else begin m_bus = a; m_inc = 1'b0; end
            m_last = a;
        end
        vectors++;
        report(tag, "bus_out", int'(bus_out), int'(m_bus));
        report(tag, "inc_out", int'(inc_out), int'(m_inc));
        report("R7", "dec_addr", int'(dec_addr), int'(exp_dec));
        in_valid = 1'b0;
    endtask

    initial begin
        #(190000 * 10);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ex_addr [8];
        logic [W-1:0] ex_bus  [8];
        logic         ex_inc  [8];
        ex_addr = '{8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd6, 8'd7, 8'd8};
        ex_bus  = '{8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd6, 8'd6, 8'd6};
        ex_inc  = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

        // R5: reset state, first address equal to the stride is a hit
        do_reset();
        apply(1'b1, 8'd1, "R5");
        apply(1'b0, 8'd0, "R6");
        // R5: first address not equal to the stride is a miss
        do_reset();
        apply(1'b1, 8'd0, "R5");
        apply(1'b1, 8'd9, "R2");

        // R8: worked stream
        apply(1'b1, 8'd40, "R2");
        for (int i = 0; i < 8; i++) begin
            apply(1'b1, ex_addr[i], "R8");
            vectors++;
            report("R8", "bus_out literal", int'(bus_out), int'(ex_bus[i]));
            report("R8", "inc_out literal", int'(inc_out), int'(ex_inc[i]));
        end
        apply(1'b0, 8'd0, "R6");
        apply(1'b0, 8'd0, "R6");
        apply(1'b1, 8'd9, "R3");

        // R4: step across the top of the range
        apply(1'b1, 8'hFE, "R2");
        apply(1'b1, 8'hFF, "R4");
        apply(1'b1, 8'h00, "R4");
        apply(1'b1, 8'h01, "R4");

        // sweep every start address: runs, idle gaps, backward and scrambled jumps
        for (int s = 0; s < 256; s++) begin
            logic [W-1:0] b;
            b = W'(s);
            apply(1'b1, b, "");
            apply(1'b1, W'(b + 8'd1), "R3");
            apply(1'b1, W'(b + 8'd2), "R3");
            apply(1'b0, W'(b + 8'd7), "R6");
            apply(1'b1, W'(b + 8'd3), "R6");
            apply(1'b1, W'(b + 8'd3), "R2");
            apply(1'b1, b, "");
            apply(1'b1, b ^ 8'h5A, "");
            apply(1'b1, W'(b - 8'd1), "");
        end
        apply(1'b1, 8'd77, "");
        apply(1'b0, 8'd0, "R7");
        apply(1'b0, 8'd0, "R7");

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule